// File: doc/BRIEF.md
# Terminal Character I/O and Interrupt Controller

This block sits beside the control unit of a small accumulator machine. It owns a one-character receive holding register, a one-character transmit holding register, a receive-full flag, a transmit-empty flag, an interrupt enable and an interrupt-pending flip-flop. A keyboard-side producer hands in characters and a printer-side consumer takes them away. The CPU runs six I/O commands against this state. Each command is picked by one bit of the instruction's low field. The CPU also gets back the control strobes that make up a hardware interrupt cycle.

The CPU asserts `io_exec` in the execute step of an I/O-class instruction and presents instruction bits 11 down to 6 on `ir_sel`. The block answers in that same cycle with `ac_load`/`ac_data` and `pc_skip`, and it commits its own state changes at the closing edge. The CPU also presents its timing step on `t_step`. When the pending flip-flop is set, the CPU runs steps 0 to 2 as an interrupt cycle instead of a fetch, and follows the three strobes this block drives.

Back-pressure rules: `kbd_ready` is high exactly while the receive register is empty. A beat offered while `kbd_ready` is low is not held. It is discarded, and `kbd_overrun` is raised. The printer side cannot stall the block. `prn_valid` pulses for one cycle per output command. The printer signals completion later with `prn_done`.

Top module: `tio_ctrl`

## Requirements
- R1: After reset the receive-full flag is 0 (`kbd_ready`=1), the transmit-empty flag is 1, the interrupt enable and pending flip-flop are 0, `kbd_overrun` and `prn_valid` are 0.
- R2: A beat with `kbd_valid`=1 while `kbd_ready`=1 loads `kbd_data` into the receive register and sets the receive-full flag at that edge, so `kbd_ready` drops in the next cycle.
- R3: A beat with `kbd_valid`=1 while `kbd_ready`=0 leaves the receive register unchanged and sets `kbd_overrun`. `kbd_overrun` stays set until the next input command, which clears it.
- R4: Input command (`ir_sel` bit 5, instruction bit 11): during the execute cycle `ac_load`=1 and `ac_data` equals the receive register; the receive-full flag clears at the closing edge.
- R5: Output command (`ir_sel` bit 4, instruction bit 10): `ac_low` is captured into the transmit register and the transmit-empty flag clears at the closing edge; in the next cycle `prn_valid` is 1 for exactly one cycle with `prn_data` equal to the captured byte.
- R6: `prn_done`=1 sets the transmit-empty flag. When it coincides with an output command, the command wins and the flag ends at 0.
- R7: Skip-on-input (`ir_sel` bit 3) drives `pc_skip`=1 in the execute cycle if the receive-full flag is 1. Skip-on-output (`ir_sel` bit 2) does the same for the transmit-empty flag.
- R8: Enable command (`ir_sel` bit 1) sets the interrupt enable and disable command (`ir_sel` bit 0) clears it; if both bits are set, disable wins.
- R9: The pending flip-flop (`irq_pending`) is set at an edge where the interrupt enable is 1, either ready flag is 1 and `t_step` is 3 or higher; it is never set when `t_step` is 0, 1 or 2.
- R10: While `irq_pending`=1, `t_step`=0, 1 and 2 drive `int_save` (AR cleared, TR taken from PC), `int_store` (memory at AR written from TR, PC cleared) and `int_finish` (PC incremented, step counter cleared), one at a time. The edge closing step 2 clears both `irq_pending` and the interrupt enable.
- R11: With `io_exec`=0, `ir_sel` has no effect: `ac_load` and `pc_skip` stay 0 and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_valid | input | 1 | Keyboard beat offered |
| kbd_data | input | CHAR_W | Keyboard character |
| kbd_ready | output | 1 | Receive register empty |
| kbd_overrun | output | 1 | A beat was dropped since the last input command |
| prn_valid | output | 1 | One-cycle pulse: new character for the printer |
| prn_data | output | CHAR_W | Transmit register |
| prn_done | input | 1 | Printer finished the last character |
| io_exec | input | 1 | I/O-class instruction in its execute step |
| ir_sel | input | 6 | Instruction bits 11 down to 6 |
| ac_low | input | CHAR_W | Accumulator low byte |
| ac_load | output | 1 | Load accumulator low byte from `ac_data` |
| ac_data | output | CHAR_W | Receive register |
| pc_skip | output | 1 | Increment PC (skip next instruction) |
| t_step | input | STEP_W | Current CPU timing step |
| irq_pending | output | 1 | Interrupt-pending flip-flop |
| int_save | output | 1 | Interrupt step 0 strobe |
| int_store | output | 1 | Interrupt step 1 strobe |
| int_finish | output | 1 | Interrupt step 2 strobe |

## Verification
The bench builds the block with CHAR_W=8 and STEP_W=4. With these values, 16 timing steps are reachable, so the step window around steps 2 and 3 can be driven on both sides. They also allow distinct byte values that show whether a dropped beat overwrote the held character. The printer stream is scored against a queue of the bytes the output commands wrote. The interrupt sequence is driven step by step, with the coincidence cases set up alongside it: output command against printer completion, enable against disable, and keyboard beat against a full register.

// File: rtl/tio_pkg.sv
package tio_pkg;
  // position of each command within ir_sel (instruction bits 11..6)
  localparam int SEL_W   = 6;
  localparam int SEL_INP = 5;
  localparam int SEL_OUT = 4;
  localparam int SEL_SKI = 3;
  localparam int SEL_SKO = 2;
  localparam int SEL_ION = 1;
  localparam int SEL_IOF = 0;

  typedef struct packed {
    logic take;   // input char to accumulator
    logic put;    // output char from accumulator
    logic ski;
    logic sko;
    logic ien_on;
    logic ien_off;
  } io_cmd_t;
endpackage

// File: rtl/tio_in_port.sv
module tio_in_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  input  logic              take,
  output logic              kbd_ready,
  output logic [CHAR_W-1:0] rx_q,
  output logic              rx_full,
  output logic              overrun
);
  logic accept, drop;

  assign kbd_ready = ~rx_full;
  assign accept    = kbd_valid & ~rx_full;
  assign drop      = kbd_valid & rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (accept) rx_q <= kbd_data;
      // an arriving character outranks the drain of an empty register
      if (accept)    rx_full <= 1'b1;
      else if (take) rx_full <= 1'b0;
      if (drop)      overrun <= 1'b1;
      else if (take) overrun <= 1'b0;
    end
  end

  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && kbd_ready |=> rx_full && !kbd_ready);
  p_drop_keeps_char_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && !kbd_ready |=> overrun && $stable(rx_q));
  p_take_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !kbd_valid |=> kbd_ready);
endmodule

// File: rtl/tio_out_port.sv
module tio_out_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [CHAR_W-1:0] ac_low,
  input  logic              prn_done,
  output logic              prn_valid,
  output logic [CHAR_W-1:0] prn_data,
  output logic              tx_empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prn_data  <= '0;
      tx_empty  <= 1'b1;
      prn_valid <= 1'b0;
    end else begin
      prn_valid <= put;
      if (put) prn_data <= ac_low;
      // a fresh character outranks a completion seen in the same cycle
      if (put)           tx_empty <= 1'b0;
      else if (prn_done) tx_empty <= 1'b1;
    end
  end

  p_put_announces_r5: assert property (@(posedge clk) disable iff (!rst_n)
    put |=> prn_valid && !tx_empty && prn_data == $past(ac_low));
  p_done_sets_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prn_done && !put |=> tx_empty);
endmodule

// File: rtl/tio_irq.sv
module tio_irq #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_on,
  input  logic              ien_off,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic [STEP_W-1:0] t_step,
  output logic              irq_pending,
  output logic              int_save,
  output logic              int_store,
  output logic              int_finish
);
  localparam logic [STEP_W-1:0] STEP_SAVE   = STEP_W'(0);
  localparam logic [STEP_W-1:0] STEP_STORE  = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_FINISH = STEP_W'(2);

  logic ien, in_fetch_window, raise;

  assign in_fetch_window = (t_step <= STEP_FINISH);
  assign raise           = ien & (rx_full | tx_empty) & ~in_fetch_window;

  assign int_save   = irq_pending & (t_step == STEP_SAVE);
  assign int_store  = irq_pending & (t_step == STEP_STORE);
  assign int_finish = irq_pending & (t_step == STEP_FINISH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien         <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      if (int_finish)   ien <= 1'b0;
      else if (ien_off) ien <= 1'b0;
      else if (ien_on)  ien <= 1'b1;
      if (int_finish)   irq_pending <= 1'b0;
      else if (raise)   irq_pending <= 1'b1;
    end
  end

  p_no_raise_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending && in_fetch_window |=> !irq_pending);
  p_finish_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_finish |=> !irq_pending && !ien);
  p_off_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ien_off |=> !ien);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_save, int_store, int_finish}));
endmodule

// File: rtl/tio_ctrl.sv
module tio_ctrl #(
  parameter int CHAR_W = 8,
  parameter int STEP_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       kbd_valid,
  input  logic [CHAR_W-1:0]          kbd_data,
  output logic                       kbd_ready,
  output logic                       kbd_overrun,
  output logic                       prn_valid,
  output logic [CHAR_W-1:0]          prn_data,
  input  logic                       prn_done,
  input  logic                       io_exec,
  input  logic [tio_pkg::SEL_W-1:0]  ir_sel,
  input  logic [CHAR_W-1:0]          ac_low,
  output logic                       ac_load,
  output logic [CHAR_W-1:0]          ac_data,
  output logic                       pc_skip,
  input  logic [STEP_W-1:0]          t_step,
  output logic                       irq_pending,
  output logic                       int_save,
  output logic                       int_store,
  output logic                       int_finish
);
  import tio_pkg::*;

  io_cmd_t           cmd;
  logic              rx_full, tx_empty;
  logic [CHAR_W-1:0] rx_q;

  always_comb begin
    cmd         = '0;
    cmd.take    = io_exec & ir_sel[SEL_INP];
    cmd.put     = io_exec & ir_sel[SEL_OUT];
    cmd.ski     = io_exec & ir_sel[SEL_SKI];
    cmd.sko     = io_exec & ir_sel[SEL_SKO];
    cmd.ien_on  = io_exec & ir_sel[SEL_ION];
    cmd.ien_off = io_exec & ir_sel[SEL_IOF];
  end

  tio_in_port #(.CHAR_W(CHAR_W)) u_in (
    .clk(clk), .rst_n(rst_n), .kbd_valid(kbd_valid), .kbd_data(kbd_data),
    .take(cmd.take), .kbd_ready(kbd_ready), .rx_q(rx_q), .rx_full(rx_full),
    .overrun(kbd_overrun)
  );

  tio_out_port #(.CHAR_W(CHAR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .put(cmd.put), .ac_low(ac_low),
    .prn_done(prn_done), .prn_valid(prn_valid), .prn_data(prn_data),
    .tx_empty(tx_empty)
  );

  tio_irq #(.STEP_W(STEP_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .ien_on(cmd.ien_on), .ien_off(cmd.ien_off),
    .rx_full(rx_full), .tx_empty(tx_empty), .t_step(t_step),
    .irq_pending(irq_pending), .int_save(int_save), .int_store(int_store),
    .int_finish(int_finish)
  );

  assign ac_load = cmd.take;
  assign ac_data = rx_q;
  assign pc_skip = (cmd.ski & rx_full) | (cmd.sko & tx_empty);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_exec |-> !ac_load && !pc_skip);
endmodule

// File: tb/sim_tio_ctrl.sv
module sim_tio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_valid = 1'b0, prn_done = 1'b0, io_exec = 1'b0;
  logic [7:0] kbd_data = '0, ac_low = '0;
  logic [5:0] ir_sel = '0;
  logic [3:0] t_step = 4'd1;
  logic       kbd_ready, kbd_overrun, prn_valid, ac_load, pc_skip;
  logic       irq_pending, int_save, int_store, int_finish;
  logic [7:0] prn_data, ac_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  localparam logic [5:0] C_INP = 6'b100000, C_OUT = 6'b010000, C_SKI = 6'b001000,
                         C_SKO = 6'b000100, C_ION = 6'b000010, C_IOF = 6'b000001;

  always #4 clk = ~clk;

  tio_ctrl #(.CHAR_W(8), .STEP_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .kbd_valid(kbd_valid), .kbd_data(kbd_data),
    .kbd_ready(kbd_ready), .kbd_overrun(kbd_overrun), .prn_valid(prn_valid),
    .prn_data(prn_data), .prn_done(prn_done), .io_exec(io_exec), .ir_sel(ir_sel),
    .ac_low(ac_low), .ac_load(ac_load), .ac_data(ac_data), .pc_skip(pc_skip),
    .t_step(t_step), .irq_pending(irq_pending), .int_save(int_save),
    .int_store(int_store), .int_finish(int_finish)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive a command for one cycle; checks go between start and finish
  task automatic op_start(input logic [5:0] sel, input logic [7:0] ac);
    io_exec = 1'b1; ir_sel = sel; ac_low = ac;
    if (sel[4]) exp_q.push_back(ac);
    #1;
  endtask
  task automatic op_end();
    @(negedge clk); io_exec = 1'b0; ir_sel = '0; #1;
  endtask
  task automatic cyc(input logic [3:0] st);
    t_step = st; @(negedge clk); #1;
  endtask
  task automatic skip_probe(input string tag, input logic [5:0] sel, input logic exp);
    op_start(sel, 8'h00); check(tag, pc_skip, exp); op_end();
  endtask

  // scoreboard monitor for the printer stream (R5)
  always @(negedge clk) begin
    if (rst_n && prn_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 stray printer beat: actual %0h expected none", prn_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (prn_data !== e) begin
          n_bad++;
          $display("FAIL R5 printer byte: actual %0h expected %0h", prn_data, e);
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R1 reset state
    check("R1 kbd_ready", kbd_ready, 1);
    check("R1 overrun", kbd_overrun, 0);
    check("R1 prn_valid", prn_valid, 0);
    check("R1 irq", irq_pending, 0);
    skip_probe("R1 R7 sko after reset", C_SKO, 1);
    skip_probe("R1 R7 ski after reset", C_SKI, 0);

    // R2 accept
    kbd_valid = 1'b1; kbd_data = 8'h41;
    @(negedge clk); #1;
    check("R2 ready drops", kbd_ready, 0);
    // R3 drop while full
    kbd_data = 8'h42;
    @(negedge clk); kbd_valid = 1'b0; #1;
    check("R3 overrun set", kbd_overrun, 1);
    skip_probe("R7 ski full", C_SKI, 1);
    // R4 input command
    op_start(C_INP, 8'h00);
    check("R4 ac_load", ac_load, 1);
    check("R3 R4 held char", ac_data, 8'h41);
    op_end();
    check("R4 ready back", kbd_ready, 1);
    check("R3 overrun cleared", kbd_overrun, 0);

    // R11 gated commands
    io_exec = 1'b0; ir_sel = C_INP | C_SKO | C_OUT; #1;
    check("R11 no ac_load", ac_load, 0);
    check("R11 no skip", pc_skip, 0);
    @(negedge clk); ir_sel = '0; #1;
    check("R11 no printer beat", prn_valid, 0);
    skip_probe("R11 tx flag kept", C_SKO, 1);

    // R5 output command
    op_start(C_OUT, 8'h5A); op_end();
    check("R5 pulse high", prn_valid, 1);
    check("R5 data", prn_data, 8'h5A);
    @(negedge clk); #1;
    check("R5 pulse one cycle", prn_valid, 0);
    skip_probe("R5 tx flag cleared", C_SKO, 0);
    // R6 completion
    prn_done = 1'b1; @(negedge clk); prn_done = 1'b0; #1;
    skip_probe("R6 done sets flag", C_SKO, 1);
    op_start(C_OUT, 8'hC3); prn_done = 1'b1; op_end(); prn_done = 1'b0;
    skip_probe("R6 output wins", C_SKO, 0);
    prn_done = 1'b1; @(negedge clk); prn_done = 1'b0; #1;

    // R9 window; tx flag is 1 from here on
    t_step = 4'd1; op_start(C_ION, 8'h00); op_end();
    cyc(4'd0); cyc(4'd1); cyc(4'd2);
    check("R9 not in steps 0-2", irq_pending, 0);
    cyc(4'd3);
    check("R9 raised at step 3", irq_pending, 1);
    // R10 interrupt cycle
    t_step = 4'd0; #1;
    check("R10 save", {int_save, int_store, int_finish}, 3'b100);
    @(negedge clk); t_step = 4'd1; #1;
    check("R10 store", {int_save, int_store, int_finish}, 3'b010);
    @(negedge clk); t_step = 4'd2; #1;
    check("R10 finish", {int_save, int_store, int_finish}, 3'b001);
    @(negedge clk); #1;
    check("R10 pending cleared", irq_pending, 0);
    cyc(4'd5);
    check("R10 enable cleared", irq_pending, 0);

    // R8 enable/disable
    t_step = 4'd1; op_start(C_ION, 8'h00); op_end();
    op_start(C_IOF, 8'h00); op_end();
    cyc(4'd5);
    check("R8 disable", irq_pending, 0);
    t_step = 4'd1; op_start(C_ION | C_IOF, 8'h00); op_end();
    cyc(4'd6);
    check("R8 disable wins", irq_pending, 0);
    t_step = 4'd1; io_exec = 1'b0; ir_sel = C_ION; @(negedge clk); ir_sel = '0;
    cyc(4'd7);
    check("R11 gated enable", irq_pending, 0);
    t_step = 4'd1; op_start(C_ION, 8'h00); op_end();
    cyc(4'd9);
    check("R8 enable", irq_pending, 1);

    check("R5 all printer bytes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule